// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block holds the eight-byte register window of one disk channel's bus-master DMA function. A host-side port reaches it with byte-addressed accesses one, two or four bytes wide. The window holds three things: a command byte, a three-bit status byte, and a 32-bit pointer to the descriptor table in memory. The pointer is made up of four bytes, and any byte-aligned slice of them can be read or written.

The block drives a downstream transfer engine. A write of the command byte with its go bit set sends the engine a one-cycle launch pulse, and the direction bit stays visible to the engine. The block also keeps the engine's descriptor-table position. The engine reports back with three events: it has moved to the next descriptor, it has finished, or it has faulted. A separate channel interrupt event can also arrive. These events update the status bits.

Every result is registered. Read data, the access-error flag and the launch pulse all appear in the cycle after the access is sampled.

Top module: `bmdma_regwin`

## Requirements
- R1: After a synchronous reset, the following are all zero: the command byte, the status bits, the pointer, the table index, `rd_valid`, `acc_err` and `eng_start`.
- R2: The window has three kinds of offset. Offset 0 is the command byte and offset 2 is the status byte. Offsets 4 to 7 are pointer bytes 0 to 3, with the least significant byte at offset 4. Offsets 1 and 3, and any other offset, are invalid.
- R3: The only legal lengths are 1, 2 and 4. The command and status bytes accept length 1 only. A pointer access at pointer byte i = offset-4 with length L is an overrun when i+L > 4.
- R4: An access that is invalid, of illegal width or an overrun raises `acc_err` for one cycle in the following cycle. It changes no state, and `rd_valid` stays low.
- R5: A legal read raises `rd_valid` in the next cycle. Byte k of the result, in bits 8k+7:8k, is the register byte at offset+k, and lanes past the length read zero. The command byte reads back as last written. The status byte reads as bit 0 active, bit 1 error, bit 2 interrupt, with the upper bits zero.
- R6: A command write with bit 0 (go) set does two things. It sets the active bit, and it gives a one-cycle `eng_start` in the next cycle. `eng_dir` always shows bit 3 of the stored command byte.
- R7: A command write with go clear resets the table index to 0, even when `eng_next` arrives in the same cycle. It does not pulse `eng_start`.
- R8: Each `eng_next` adds one to the table index, which wraps at its width.
- R9: `eng_done` clears the active bit and sets the interrupt bit. `chan_irq` sets the interrupt bit. `eng_fault` sets the error bit. An event takes effect after a register write in the same cycle, so it overrides that write.
- R10: A one-byte status write replaces all three status bits with bits 2:0 of the written byte.
- R11: A pointer write changes only the addressed bytes, and `eng_ptr` shows the full pointer from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 3 | Byte offset in the window |
| acc_len | input | 3 | Access length in bytes |
| acc_wdata | input | 32 | Write data, lane k goes to offset+k |
| eng_next | input | 1 | Engine moved to the next descriptor |
| eng_done | input | 1 | Engine finished the transfer |
| eng_fault | input | 1 | Engine hit an error |
| chan_irq | input | 1 | Channel raised its interrupt |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Access rejected |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_dir | output | 1 | Transfer direction from command bit 3 |
| eng_ptr | output | 32 | Descriptor table pointer |
| tbl_index | output | 16 | Current descriptor table index |

## Verification
The bench aims at pointer slices that run off the top of the four bytes, for example offset 6 with length 4 and offset 5 with length 4. A design with a wrong overrun bound would either write the wrong bytes or reject a legal access. The bench also targets wide accesses to the command and status bytes, and the unused offsets. A design that decodes these loosely would change state when it should report an error.

Events that collide with register writes are also checked. One case is completion in the same cycle as a go write, which must leave the channel inactive. Another is `eng_next` in the same cycle as a go-clear write, which must leave the index at zero. A design that gives priority in the wrong order would show a stale active bit or an index of one. Random traffic is compared byte by byte against a bench model, which catches lane misplacement and unmasked upper lanes on short reads.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned PTR_BYTES = 4;
  localparam logic [2:0]  OFS_CMD   = 3'd0;
  localparam logic [2:0]  OFS_STAT  = 3'd2;
  localparam int unsigned CMD_GO    = 0;
  localparam int unsigned CMD_DIR   = 3;
  localparam int unsigned ST_ACT    = 0;
  localparam int unsigned ST_ERR    = 1;
  localparam int unsigned ST_IRQ    = 2;
  localparam int unsigned ST_W      = 3;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CMD  = 2'd1,
    TGT_STAT = 2'd2,
    TGT_PTR  = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic       ok;
    logic [1:0] lane;
  } dec_t;
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int unsigned OFS_W = 3,
  parameter int unsigned LEN_W = 3
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [LEN_W-1:0] len,
  output dec_t             dec
);
  logic       width_ok;
  logic [3:0] span_end;

  always_comb begin
    width_ok = (len == LEN_W'(1)) || (len == LEN_W'(2)) || (len == LEN_W'(4));
    span_end = {2'b00, offset[1:0]} + 4'(len);
    dec.lane = offset[1:0];
    dec.tgt  = TGT_NONE;
    dec.ok   = 1'b0;
    if (offset == OFS_W'(OFS_CMD)) begin
      dec.tgt = TGT_CMD;
      dec.ok  = (len == LEN_W'(1));
    end else if (offset == OFS_W'(OFS_STAT)) begin
      dec.tgt = TGT_STAT;
      dec.ok  = (len == LEN_W'(1));
    end else if (offset[2]) begin
      dec.tgt = TGT_PTR;
      dec.ok  = width_ok && (span_end <= 4'(PTR_BYTES));
    end
  end
endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr
  import bmdma_pkg::*;
#(
  parameter int unsigned NBYTES = PTR_BYTES,
  parameter int unsigned LEN_W  = 3,
  localparam int unsigned DW    = 8 * NBYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       lane,
  input  logic [LEN_W-1:0] len,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    ptr_q,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] shifted;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic [3:0] BI = 4'(b);
    logic       hit;
    logic [2:0] rel;
    logic [7:0] byte_in;

    always_comb begin
      rel     = 3'(BI) - {1'b0, lane};
      hit     = wr_en && (BI >= {2'b00, lane}) && (BI < ({2'b00, lane} + 4'(len)));
      byte_in = wdata[{rel[1:0], 3'b000} +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[8*b +: 8] <= 8'h00;
      end else if (hit) begin
        ptr_q[8*b +: 8] <= byte_in;
      end
    end

    always_comb begin
      rdata[8*b +: 8] = (4'(b) < 4'(len)) ? shifted[8*b +: 8] : 8'h00;
    end
  end

  always_comb shifted = ptr_q >> {lane, 3'b000};
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             stat_wr,
  input  logic [7:0]       wbyte,
  input  logic             eng_next,
  input  logic             eng_done,
  input  logic             eng_fault,
  input  logic             chan_irq,
  output logic [7:0]       cmd_q,
  output logic [ST_W-1:0]  stat_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             start_q
);
  logic [ST_W-1:0] stat_d;
  logic            launch;
  logic            halt;

  always_comb begin
    launch = cmd_wr && wbyte[CMD_GO];
    halt   = cmd_wr && !wbyte[CMD_GO];
    stat_d = stat_q;
    if (stat_wr) stat_d = wbyte[ST_W-1:0];
    if (launch) stat_d[ST_ACT] = 1'b1;
    if (eng_done) begin
      stat_d[ST_ACT] = 1'b0;
      stat_d[ST_IRQ] = 1'b1;
    end
    if (chan_irq)  stat_d[ST_IRQ] = 1'b1;
    if (eng_fault) stat_d[ST_ERR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= 8'h00;
      stat_q  <= '0;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch;
      stat_q  <= stat_d;
      if (cmd_wr) cmd_q <= wbyte;
      if (halt) idx_q <= '0;
      else if (eng_next) idx_q <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
  import bmdma_pkg::*;
#(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned OFS_W = 3,
  parameter int unsigned LEN_W = 3,
  localparam int unsigned DW   = 8 * PTR_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [OFS_W-1:0] acc_offset,
  input  logic [LEN_W-1:0] acc_len,
  input  logic [DW-1:0]    acc_wdata,
  input  logic             eng_next,
  input  logic             eng_done,
  input  logic             eng_fault,
  input  logic             chan_irq,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             acc_err,
  output logic             eng_start,
  output logic             eng_dir,
  output logic [DW-1:0]    eng_ptr,
  output logic [IDX_W-1:0] tbl_index
);
  dec_t            dec;
  logic            legal;
  logic            cmd_wr;
  logic            stat_wr;
  logic            ptr_wr;
  logic [7:0]      cmd_q;
  logic [ST_W-1:0] stat_q;
  logic [DW-1:0]   ptr_rd;
  logic [DW-1:0]   rd_mux;

  bmdma_decode #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_dec (
    .offset (acc_offset),
    .len    (acc_len),
    .dec    (dec)
  );

  always_comb begin
    legal   = acc_valid && dec.ok;
    cmd_wr  = legal && acc_write && (dec.tgt == TGT_CMD);
    stat_wr = legal && acc_write && (dec.tgt == TGT_STAT);
    ptr_wr  = legal && acc_write && (dec.tgt == TGT_PTR);
  end

  bmdma_ptr #(.NBYTES(PTR_BYTES), .LEN_W(LEN_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_en (ptr_wr),
    .lane  (dec.lane),
    .len   (acc_len),
    .wdata (acc_wdata),
    .ptr_q (eng_ptr),
    .rdata (ptr_rd)
  );

  bmdma_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .stat_wr   (stat_wr),
    .wbyte     (acc_wdata[7:0]),
    .eng_next  (eng_next),
    .eng_done  (eng_done),
    .eng_fault (eng_fault),
    .chan_irq  (chan_irq),
    .cmd_q     (cmd_q),
    .stat_q    (stat_q),
    .idx_q     (tbl_index),
    .start_q   (eng_start)
  );

  always_comb begin
    unique case (dec.tgt)
      TGT_CMD:  rd_mux = DW'(cmd_q);
      TGT_STAT: rd_mux = DW'(stat_q);
      TGT_PTR:  rd_mux = ptr_rd;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= legal && !acc_write;
      rd_data  <= (legal && !acc_write) ? rd_mux : '0;
      acc_err  <= acc_valid && !dec.ok;
    end
  end

  assign eng_dir = cmd_q[CMD_DIR];
endmodule

// File: rtl/bmdma_regwin_chk.sv
module bmdma_regwin_chk #(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned OFS_W = 3,
  parameter int unsigned LEN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [OFS_W-1:0] acc_offset,
  input logic [LEN_W-1:0] acc_len,
  input logic [31:0]      acc_wdata,
  input logic             eng_next,
  input logic             eng_done,
  input logic             chan_irq,
  input logic             rd_valid,
  input logic             acc_err,
  input logic             eng_start,
  input logic [31:0]      eng_ptr,
  input logic [IDX_W-1:0] tbl_index,
  input logic [2:0]       stat_q
);
  // R4
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && acc_err));

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $stable(eng_ptr));

  // R5
  rd_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write));

  // R6
  start_act_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_start && !$past(eng_done)) |-> stat_q[0]);

  // R9
  done_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(eng_done) |-> (!stat_q[0] && stat_q[2]));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(chan_irq) |-> stat_q[2]);

  // R7
  idx_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_offset == OFS_W'(0) && acc_len == LEN_W'(1) && !acc_wdata[0])
      |=> (tbl_index == '0));

  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_next && !(acc_valid && acc_write && acc_offset == OFS_W'(0)))
      |=> (tbl_index == $past(tbl_index) + IDX_W'(1)));
endmodule

bind bmdma_regwin bmdma_regwin_chk #(.IDX_W(IDX_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_offset (acc_offset),
  .acc_len    (acc_len),
  .acc_wdata  (acc_wdata),
  .eng_next   (eng_next),
  .eng_done   (eng_done),
  .chan_irq   (chan_irq),
  .rd_valid   (rd_valid),
  .acc_err    (acc_err),
  .eng_start  (eng_start),
  .eng_ptr    (eng_ptr),
  .tbl_index  (tbl_index),
  .stat_q     (stat_q)
);

// File: tb/bmdma_regwin_tb.sv
module bmdma_regwin_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0]  acc_offset = '0, acc_len = '0;
  logic [31:0] acc_wdata = '0;
  logic        eng_next = 1'b0, eng_done = 1'b0, eng_fault = 1'b0, chan_irq = 1'b0;
  logic        rd_valid, acc_err, eng_start, eng_dir;
  logic [31:0] rd_data, eng_ptr;
  logic [15:0] tbl_index;

  int n_chk = 0, n_bad = 0;

  // bench model of the register state
  logic [7:0]  m_cmd = '0;
  logic [2:0]  m_stat = '0;
  logic [31:0] m_ptr = '0;
  logic [15:0] m_idx = '0;

  always #(CLK_P/2) clk = ~clk;

  bmdma_regwin u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_len(acc_len), .acc_wdata(acc_wdata),
    .eng_next(eng_next), .eng_done(eng_done), .eng_fault(eng_fault), .chan_irq(chan_irq),
    .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err), .eng_start(eng_start),
    .eng_dir(eng_dir), .eng_ptr(eng_ptr), .tbl_index(tbl_index)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal_acc(logic [2:0] off, logic [2:0] len);
    bit wok = (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
    if (off == 3'd0 || off == 3'd2) return len == 3'd1;
    if (off >= 3'd4) return wok && ((int'(off) - 4 + int'(len)) <= 4);
    return 1'b0;
  endfunction

  // one cycle: drive at negedge, model, check after the edge
  task automatic step(bit v, bit w, logic [2:0] off, logic [2:0] len, logic [31:0] wd,
                      bit nx, bit dn, bit ft, bit ir, string tag);
    bit          ok, e_rv, e_err, e_start, clr;
    logic [31:0] e_rd;
    int          i;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_offset = off; acc_len = len; acc_wdata = wd;
    eng_next = nx; eng_done = dn; eng_fault = ft; chan_irq = ir;
    ok = v && legal_acc(off, len);
    e_err = v && !ok;
    e_rv = ok && !w;
    e_rd = '0; e_start = 0; clr = 0;
    i = int'(off) - 4;
    if (e_rv) begin
      if (off == 3'd0) e_rd = {24'h0, m_cmd};
      else if (off == 3'd2) e_rd = {29'h0, m_stat};
      else for (int k = 0; k < int'(len); k++) e_rd[8*k +: 8] = m_ptr[8*(i+k) +: 8];
    end
    if (ok && w) begin
      if (off == 3'd0) begin
        m_cmd = wd[7:0];
        if (wd[0]) begin m_stat[0] = 1'b1; e_start = 1; end
        else clr = 1;
      end else if (off == 3'd2) m_stat = wd[2:0];
      else for (int k = 0; k < int'(len); k++) m_ptr[8*(i+k) +: 8] = wd[8*k +: 8];
    end
    if (clr) m_idx = '0; else if (nx) m_idx = m_idx + 16'd1;
    if (dn) begin m_stat[0] = 1'b0; m_stat[2] = 1'b1; end
    if (ir) m_stat[2] = 1'b1;
    if (ft) m_stat[1] = 1'b1;
    @(posedge clk); #1;
    chk({tag, " R5 rd_valid"}, 32'(rd_valid), 32'(e_rv));
    chk({tag, " R5 rd_data"}, rd_data, e_rd);
    chk({tag, " R4 acc_err"}, 32'(acc_err), 32'(e_err));
    chk({tag, " R6 eng_start"}, 32'(eng_start), 32'(e_start));
    chk({tag, " R6 eng_dir"}, 32'(eng_dir), 32'(m_cmd[3]));
    chk({tag, " R11 eng_ptr"}, eng_ptr, m_ptr);
    chk({tag, " R8 tbl_index"}, 32'(tbl_index), 32'(m_idx));
  endtask

  task automatic rd_stat(string tag);
    step(1, 0, 3'd2, 3'd1, 0, 0, 0, 0, 0, tag);
  endtask

  bit finished = 0;

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d3a_55c1));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state at ports
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 acc_err", 32'(acc_err), 0);
    chk("R1 eng_start", 32'(eng_start), 0);
    chk("R1 eng_ptr", eng_ptr, 0);
    chk("R1 tbl_index", 32'(tbl_index), 0);
    step(1, 0, 3'd0, 3'd1, 0, 0, 0, 0, 0, "R1 cmd");
    rd_stat("R1 stat");
    step(1, 0, 3'd4, 3'd4, 0, 0, 0, 0, 0, "R1 ptr");

    // R2 / R11 pointer byte order and partial writes
    step(1, 1, 3'd4, 3'd4, 32'h4433_2211, 0, 0, 0, 0, "R2 ptr full wr");
    step(1, 0, 3'd7, 3'd1, 0, 0, 0, 0, 0, "R2 top byte");
    step(1, 1, 3'd5, 3'd2, 32'h0000_bbaa, 0, 0, 0, 0, "R11 mid wr");
    step(1, 0, 3'd6, 3'd2, 0, 0, 0, 0, 0, "R11 mid rd");
    // R2 invalid offsets
    step(1, 1, 3'd1, 3'd1, 32'hff, 0, 0, 0, 0, "R2 off1");
    step(1, 0, 3'd3, 3'd1, 0, 0, 0, 0, 0, "R2 off3");
    // R3 width and overrun
    step(1, 1, 3'd0, 3'd2, 32'h1, 0, 0, 0, 0, "R3 cmd wide");
    step(1, 1, 3'd2, 3'd4, 32'h7, 0, 0, 0, 0, "R3 stat wide");
    step(1, 1, 3'd6, 3'd4, 32'hdead_beef, 0, 0, 0, 0, "R3 overrun6");
    step(1, 1, 3'd5, 3'd4, 32'hdead_beef, 0, 0, 0, 0, "R3 overrun5");
    step(1, 0, 3'd4, 3'd3, 0, 0, 0, 0, 0, "R3 len3");
    step(1, 0, 3'd6, 3'd2, 0, 0, 0, 0, 0, "R3 edge ok");
    // R6 start with direction
    step(1, 1, 3'd0, 3'd1, 32'h09, 0, 0, 0, 0, "R6 go read");
    rd_stat("R6 active");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 next");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 next2");
    // R7 stop clears index even with next
    step(1, 1, 3'd0, 3'd1, 32'h08, 1, 0, 0, 0, "R7 stop+next");
    step(1, 0, 3'd0, 3'd1, 0, 0, 0, 0, 0, "R5 cmd readback");
    // R9 go + done same cycle leaves inactive
    step(1, 1, 3'd0, 3'd1, 32'h01, 0, 1, 0, 0, "R9 go+done");
    rd_stat("R9 after done");
    // R10 status overwrite, then events
    step(1, 1, 3'd2, 3'd1, 32'hf8, 0, 0, 0, 0, "R10 clear");
    rd_stat("R10 cleared");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 irq+fault");
    rd_stat("R9 irq fault");
    step(1, 1, 3'd2, 3'd1, 32'h0, 0, 0, 0, 1, "R9 wr vs irq");
    rd_stat("R9 irq wins");

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] off = 3'($urandom_range(0, 7));
      logic [2:0] len = 3'($urandom_range(1, 4));
      bit v  = ($urandom_range(0, 3) != 0);
      bit w  = $urandom_range(0, 1) == 1;
      bit nx = ($urandom_range(0, 5) == 0);
      bit dn = ($urandom_range(0, 9) == 0);
      bit ft = ($urandom_range(0, 19) == 0);
      bit ir = ($urandom_range(0, 9) == 0);
      step(v, w, off, len, $urandom, nx, dn, ft, ir, "rand");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule